// File: doc/BRIEF.md
# Synchronous Host Bus Write Slave

This block sits on the device side of a clocked host bus and accepts byte writes. The bus master drives an active-low chip select, a direction line (low means write), an active-low write strobe, a 15-bit address and a data byte. Every input is looked at only on the rising edge of the bus clock. A write begins when chip select, direction and strobe are all seen low on the same edge. The block then holds its ready output low for a fixed number of clock edges and stores the byte in the decoded target. On that same edge it raises ready.

The address space holds four separately placed windows: a small control register file, a transmit message buffer, and two cell insertion memories (one for the transmit path, one for the receive path). Each window has a base and a size set by parameters. Writes that land outside every window still finish the handshake but store nothing. Each storage target has a combinational read-back port so its contents can be inspected. Read cycles are not served: they produce no ready and change nothing.

Top module: `hbus_wr_slave`

## Requirements
- R1: After reset, ready is low and every byte of all four storage targets reads back as zero.
- R2: A write starts only on a rising edge where chip select, direction and write strobe are all sampled low. A cycle with direction high (a read) never raises ready and stores nothing.
- R3: Ready rises exactly WAIT_CYCLES edges after the starting edge (default 2). A bench sampling between edges first sees it high after edge number WAIT_CYCLES+1, counting the starting edge as 1.
- R4: The byte and address present on the edge where ready is driven high are stored into the decoded target at offset address minus window base.
- R5: Ready stays high while chip select and write strobe remain low. No further write happens in that time, even if address or data change. Ready returns low on the first edge that samples either signal high.
- R6: If chip select or the write strobe is sampled high before ready has risen, the cycle is dropped: ready stays low and nothing is stored.
- R7: Addresses in [REG_BASE, REG_BASE+REG_SIZE) write the register file (default base 0x0000, 16 bytes).
- R8: Addresses in [MSG_BASE, MSG_BASE+MSG_SIZE) write the transmit message buffer (default base 0x0400, 64 bytes).
- R9: Addresses in [TXC_BASE, TXC_BASE+TXC_SIZE) write the transmit cell memory (default 0x0800, 16 bytes). Addresses in [RXC_BASE, RXC_BASE+RXC_SIZE) write the receive cell memory (default 0x0C00, 16 bytes).
- R10: A write to an address outside all windows completes the handshake with normal ready timing and leaves all storage unchanged.
- R11: Each read-back port returns, in the same cycle, the stored byte at the offset it is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rw_n | input | 1 | Direction, low = write |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data byte |
| rdy | output | 1 | Ready, high when the write has been taken |
| reg_rb_addr | input | log2(REG_SIZE) | Register file read-back offset |
| reg_rb_data | output | DATA_W | Register file read-back byte |
| msg_rb_addr | input | log2(MSG_SIZE) | Message buffer read-back offset |
| msg_rb_data | output | DATA_W | Message buffer read-back byte |
| txc_rb_addr | input | log2(TXC_SIZE) | Transmit cell memory read-back offset |
| txc_rb_data | output | DATA_W | Transmit cell memory read-back byte |
| rxc_rb_addr | input | log2(RXC_SIZE) | Receive cell memory read-back offset |
| rxc_rb_data | output | DATA_W | Receive cell memory read-back byte |

## Verification
A wait counter stuck or off by one moves the ready rise by a whole clock edge, and the edge-counting handshake task catches this on the first write. If the phase register fails to leave the completed state, ready stays high after the strobe is released, which shows one edge later. A phase that does not wait for release lets a second, changed byte overwrite the first, which a read-back after the hold shows. Decode or offset faults put bytes in the wrong window or offset. The full read-back comparison after every scenario exposes these within the same test.

// File: rtl/hbus_wr_slave.sv
module hbus_wr_slave #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 2,
  parameter int REG_BASE    = 'h0000,
  parameter int REG_SIZE    = 16,
  parameter int MSG_BASE    = 'h0400,
  parameter int MSG_SIZE    = 64,
  parameter int TXC_BASE    = 'h0800,
  parameter int TXC_SIZE    = 16,
  parameter int RXC_BASE    = 'h0C00,
  parameter int RXC_SIZE    = 16,
  localparam int REG_AW = $clog2(REG_SIZE),
  localparam int MSG_AW = $clog2(MSG_SIZE),
  localparam int TXC_AW = $clog2(TXC_SIZE),
  localparam int RXC_AW = $clog2(RXC_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rdy,
  input  logic [REG_AW-1:0] reg_rb_addr,
  output logic [DATA_W-1:0] reg_rb_data,
  input  logic [MSG_AW-1:0] msg_rb_addr,
  output logic [DATA_W-1:0] msg_rb_data,
  input  logic [TXC_AW-1:0] txc_rb_addr,
  output logic [DATA_W-1:0] txc_rb_data,
  input  logic [RXC_AW-1:0] rxc_rb_addr,
  output logic [DATA_W-1:0] rxc_rb_data
);
  localparam int CW = $clog2(WAIT_CYCLES + 1) + 1;
  localparam logic [CW-1:0] WAIT_N = CW'(WAIT_CYCLES);
  localparam logic [ADDR_W-1:0] REG_B = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] MSG_B = ADDR_W'(MSG_BASE);
  localparam logic [ADDR_W-1:0] TXC_B = ADDR_W'(TXC_BASE);
  localparam logic [ADDR_W-1:0] RXC_B = ADDR_W'(RXC_BASE);
  localparam logic [ADDR_W-1:0] REG_N = ADDR_W'(REG_SIZE);
  localparam logic [ADDR_W-1:0] MSG_N = ADDR_W'(MSG_SIZE);
  localparam logic [ADDR_W-1:0] TXC_N = ADDR_W'(TXC_SIZE);
  localparam logic [ADDR_W-1:0] RXC_N = ADDR_W'(RXC_SIZE);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_DONE} phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [DATA_W-1:0] reg_mem [REG_SIZE];
  logic [DATA_W-1:0] msg_mem [MSG_SIZE];
  logic [DATA_W-1:0] txc_mem [TXC_SIZE];
  logic [DATA_W-1:0] rxc_mem [RXC_SIZE];

  wire released = cs_n | we_n;
  wire start    = (phase == PH_IDLE) & ~cs_n & ~rw_n & ~we_n;
  wire commit   = (phase == PH_WAIT) & ~released & (cnt == WAIT_N);

  wire [ADDR_W-1:0] reg_off = addr - REG_B;
  wire [ADDR_W-1:0] msg_off = addr - MSG_B;
  wire [ADDR_W-1:0] txc_off = addr - TXC_B;
  wire [ADDR_W-1:0] rxc_off = addr - RXC_B;

  wire reg_hit = reg_off < REG_N;
  wire msg_hit = !reg_hit && (msg_off < MSG_N);
  wire txc_hit = !reg_hit && !msg_hit && (txc_off < TXC_N);
  wire rxc_hit = !reg_hit && !msg_hit && !txc_hit && (rxc_off < RXC_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rdy   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_WAIT;
          cnt   <= CW'(1);
        end
        PH_WAIT: begin
          if (released) phase <= PH_IDLE;
          else if (commit) begin
            phase <= PH_DONE;
            rdy   <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
        PH_DONE: if (released) begin
          phase <= PH_IDLE;
          rdy   <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_SIZE; i++) reg_mem[i] <= '0;
      for (int i = 0; i < MSG_SIZE; i++) msg_mem[i] <= '0;
      for (int i = 0; i < TXC_SIZE; i++) txc_mem[i] <= '0;
      for (int i = 0; i < RXC_SIZE; i++) rxc_mem[i] <= '0;
    end else if (commit) begin
      if (reg_hit) reg_mem[reg_off[REG_AW-1:0]] <= wdata;
      if (msg_hit) msg_mem[msg_off[MSG_AW-1:0]] <= wdata;
      if (txc_hit) txc_mem[txc_off[TXC_AW-1:0]] <= wdata;
      if (rxc_hit) rxc_mem[rxc_off[RXC_AW-1:0]] <= wdata;
    end
  end

  assign reg_rb_data = reg_mem[reg_rb_addr];
  assign msg_rb_data = msg_mem[msg_rb_addr];
  assign txc_rb_data = txc_mem[txc_rb_addr];
  assign rxc_rb_data = rxc_mem[rxc_rb_addr];
endmodule

// File: rtl/hbus_wr_slave_chk.sv
module hbus_wr_slave_chk #(
  parameter int WAIT_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic we_n,
  input logic rdy
);
  int unsigned streak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak <= 0;
    else if (cs_n || we_n) streak <= 0;
    else if (streak <= WAIT_CYCLES) streak <= streak + 1;
  end

  AST_RDY_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(!cs_n && !we_n)) else $error("AST_RDY_NEEDS_HOLD"); // R6
  AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (streak >= WAIT_CYCLES + 1)) else $error("AST_WAIT_LENGTH"); // R3
  AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && (cs_n || we_n)) |=> !rdy) else $error("AST_RDY_RELEASE"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && (cs_n || we_n)) |=> !rdy) else $error("AST_IDLE_QUIET"); // R2
endmodule

bind hbus_wr_slave hbus_wr_slave_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .rdy(rdy)
);

// File: tb/hbus_wr_slave_bench.sv
`timescale 1ns/1ps
module hbus_wr_slave_bench;
  localparam int WAITC = 2;
  logic clk = 0, rst_n = 0, cs_n = 1, rw_n = 1, we_n = 1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic rdy;
  logic [3:0] reg_ra = '0, txc_ra = '0, rxc_ra = '0;
  logic [5:0] msg_ra = '0;
  logic [7:0] reg_rd, msg_rd, txc_rd, rxc_rd;
  logic [7:0] e_reg [16], e_msg [64], e_txc [16], e_rxc [16];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  hbus_wr_slave u_hbus_wr_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdy(rdy),
    .reg_rb_addr(reg_ra), .reg_rb_data(reg_rd),
    .msg_rb_addr(msg_ra), .msg_rb_data(msg_rd),
    .txc_rb_addr(txc_ra), .txc_rb_data(txc_rd),
    .rxc_rb_addr(rxc_ra), .rxc_rb_data(rxc_rd));

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int miss = 0;
    for (int i = 0; i < 16; i++) begin
      reg_ra = 4'(i); txc_ra = 4'(i); rxc_ra = 4'(i); #1;
      if (reg_rd !== e_reg[i]) begin miss++; $display("FAIL %s reg[%0d] actual=%0h expected=%0h", req, i, reg_rd, e_reg[i]); end
      if (txc_rd !== e_txc[i]) begin miss++; $display("FAIL %s txc[%0d] actual=%0h expected=%0h", req, i, txc_rd, e_txc[i]); end
      if (rxc_rd !== e_rxc[i]) begin miss++; $display("FAIL %s rxc[%0d] actual=%0h expected=%0h", req, i, rxc_rd, e_rxc[i]); end
    end
    for (int i = 0; i < 64; i++) begin
      msg_ra = 6'(i); #1;
      if (msg_rd !== e_msg[i]) begin miss++; $display("FAIL %s msg[%0d] actual=%0h expected=%0h", req, i, msg_rd, e_msg[i]); end
    end
    total++;
    if (miss != 0) bad++;
  endtask

  function automatic void model_write(input int a, input logic [7:0] d);
    if (a < 16) e_reg[a] = d;
    else if (a >= 'h400 && a < 'h440) e_msg[a - 'h400] = d;
    else if (a >= 'h800 && a < 'h810) e_txc[a - 'h800] = d;
    else if (a >= 'hC00 && a < 'hC10) e_rxc[a - 'hC00] = d;
  endfunction

  // drive a write and return the edge count at which ready was first seen high
  task automatic begin_write(input int a, input logic [7:0] d, output int edges);
    @(negedge clk);
    cs_n = 0; rw_n = 0; we_n = 0; addr = 15'(a); wdata = d;
    edges = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      edges++;
      if (rdy) break;
    end
  endtask

  task automatic release_bus(input string req);
    cs_n = 1; we_n = 1; rw_n = 1;
    @(posedge clk); @(negedge clk);
    chk(req, int'(rdy), 0, "ready after release");
  endtask

  task automatic t_reset;
    chk("R1", int'(rdy), 0, "ready at reset");
    compare_all("R1");
  endtask

  task automatic t_write(input string req, input int a, input logic [7:0] d);
    int e;
    begin_write(a, d, e);
    chk("R3", e, WAITC + 1, "edges to ready");
    chk(req, int'(rdy), 1, "ready seen");
    model_write(a, d);
    release_bus("R5");
    compare_all(req);
  endtask

  task automatic t_hold;
    int e;
    begin_write('h005, 8'hA5, e);
    chk("R3", e, WAITC + 1, "edges to ready (hold)");
    model_write('h005, 8'hA5);
    wdata = 8'h3C; addr = 15'h006;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R5", int'(rdy), 1, "ready held");
    end
    release_bus("R5");
    compare_all("R5");
  endtask

  task automatic t_read;
    @(negedge clk);
    cs_n = 0; rw_n = 1; we_n = 0; addr = 15'h002; wdata = 8'h77;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R2", int'(rdy), 0, "ready during read");
    end
    cs_n = 1; we_n = 1;
    @(posedge clk); @(negedge clk);
    compare_all("R2");
  endtask

  task automatic t_abort;
    @(negedge clk);
    cs_n = 0; rw_n = 0; we_n = 0; addr = 15'h0803; wdata = 8'hEE;
    @(posedge clk); @(negedge clk);
    we_n = 1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R6", int'(rdy), 0, "ready after abort");
    end
    cs_n = 1;
    compare_all("R6");
  endtask

  task automatic t_unmapped;
    int e;
    begin_write('h7123, 8'h99, e);
    chk("R10", e, WAITC + 1, "edges to ready unmapped");
    release_bus("R10");
    compare_all("R10");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin e_reg[i] = 0; e_txc[i] = 0; e_rxc[i] = 0; end
    for (int i = 0; i < 64; i++) e_msg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write("R7", 'h000, 8'h11);
    t_write("R7", 'h00F, 8'h22);
    t_write("R8", 'h400, 8'h33);
    t_write("R8", 'h43F, 8'h44);
    t_write("R9", 'h800, 8'h55);
    t_write("R9", 'h80F, 8'h66);
    t_write("R9", 'hC07, 8'h77);
    t_write("R4", 'h410, 8'h88);
    t_hold();
    t_read();
    t_abort();
    t_unmapped();
    t_write("R11", 'hC0F, 8'hF0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule